// File: doc/BRIEF.md
# Infrared Pulse Encoder/Decoder

This block sits between the bit-serial side of a UART and an infrared transceiver. It runs from the system clock and uses a one-cycle enable that fires once per 16x baud period. When infrared mode is on, the transmit side sends every zero bit as a short high pulse of three 16x periods, and keeps the transceiver drive low at all other times. The receive side turns each pulse it detects back into a low bit, as a synchronized level that an ordinary 16x-oversampling receiver can sample.

When infrared mode is off, both directions pass straight through. The NRZ transmit level goes to the transceiver pin, and the raw receive input goes to the NRZ output. Baud generation, framing and buffering are handled elsewhere.

Top module: `irda_codec`

## Requirements
- R1: With `ir_en_i` low, `ir_tx_o` equals `tx_nrz_i`, with no register between them.
- R2: With `ir_en_i` low, `rx_nrz_o` equals `ir_rx_i`, with no register between them.
- R3: In infrared mode, a tick that samples a zero bit at the start of a bit cell starts a pulse. `ir_tx_o` goes high on the clock edge of that tick. A bit cell starts at the first tick that samples a changed level, and then every 16 ticks.
- R4: Each pulse keeps `ir_tx_o` high for exactly 3 tick periods. It falls on the third tick after the tick that started it.
- R5: In infrared mode, a bit cell holding a one produces no pulse, and `ir_tx_o` stays low while the line is idle.
- R6: Consecutive zero bits each produce their own pulse. The pulses start 16 ticks apart.
- R7: In infrared mode, `rx_nrz_o` goes low three clock edges after `ir_rx_i` rises: two synchronizer stages plus one edge-detect register. A high `ir_rx_i` means a received pulse.
- R8: After a detected pulse, `rx_nrz_o` stays low until 16 ticks have elapsed and then returns high. A new pulse during that window restarts the 16-tick count.
- R9: After reset, with infrared mode on, `ir_tx_o` is low and `rx_nrz_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable, once per 16x baud period |
| ir_en_i | input | 1 | 1 selects infrared mode, 0 selects passthrough |
| tx_nrz_i | input | 1 | NRZ transmit bit from the UART |
| ir_rx_i | input | 1 | Raw input from the infrared receiver |
| ir_tx_o | output | 1 | Drive to the infrared transmitter |
| rx_nrz_o | output | 1 | NRZ receive bit to the UART |

## Verification
Each transmit pulse is due on the clock edge of the tick that samples the zero bit. With a tick every fourth clock and the bit driven just after a tick, that edge is four clocks after the drive. The pulse falls twelve clocks later. The receive output falls three clocks after the input rises. It comes back on the sixteenth tick after the detection edge, or after the latest retrigger. Passthrough results are due within the same cycle. The driver pushes each expected value into a queue tagged with its exact clock number. A monitor samples two nanoseconds after each rising edge and checks only the entries due in that cycle, so no check depends on the order of processes at an edge.

// File: rtl/irda_pkg.sv
package irda_pkg;
  localparam int unsigned IRDA_OVS   = 16;
  localparam int unsigned IRDA_PULSE = 3;
  localparam int unsigned IRDA_SYNC  = 2;
endpackage

// File: rtl/irda_tx_enc.sv
module irda_tx_enc #(
  parameter int unsigned OVS   = irda_pkg::IRDA_OVS,
  parameter int unsigned PULSE = irda_pkg::IRDA_PULSE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic tx_i,
  output logic pulse_o
);
  localparam int unsigned PH_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned PC_W = $clog2(PULSE + 1);
  localparam int unsigned PW_W = $clog2(PULSE + 2);

  logic            tx_q;
  logic [PH_W-1:0] phase_q;
  logic [PC_W-1:0] pc_q;
  logic            bit_edge, cell_start;

  assign bit_edge   = (tx_i != tx_q);
  assign cell_start = bit_edge || (phase_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q    <= 1'b1;
      phase_q <= '0;
      pc_q    <= '0;
    end else if (tick_i) begin
      tx_q <= tx_i;
      // realign the bit cell on every level change
      if (bit_edge)                          phase_q <= PH_W'(1);
      else if (phase_q == PH_W'(OVS - 1))    phase_q <= '0;
      else                                   phase_q <= phase_q + PH_W'(1);
      if (cell_start && !tx_i && en_i)       pc_q <= PC_W'(PULSE);
      else if (pc_q != '0)                   pc_q <= pc_q - PC_W'(1);
    end
  end

  assign pulse_o = (pc_q != '0);

  // ticks seen while the pulse is high
  logic [PW_W-1:0] pw_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pw_q <= '0;
    else if (!pulse_o)                pw_q <= '0;
    else if (tick_i && pw_q != '1)    pw_q <= pw_q + PW_W'(1);
  end

  assert_pulse_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(tick_i && !tx_i && en_i));

  assert_pulse_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pw_q <= PW_W'(PULSE));
endmodule

// File: rtl/irda_rx_dec.sv
module irda_rx_dec #(
  parameter int unsigned OVS  = irda_pkg::IRDA_OVS,
  parameter int unsigned SYNC = irda_pkg::IRDA_SYNC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic rx_i,
  output logic busy_o
);
  localparam int unsigned HC_W = $clog2(OVS + 1);
  localparam int unsigned BC_W = $clog2(OVS + 2);

  logic [SYNC:0]   sync_q;
  logic            rise;
  logic [HC_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC-1:0], rx_i};
  end

  assign rise = sync_q[SYNC-1] && !sync_q[SYNC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        hold_q <= '0;
    else if (rise && en_i)              hold_q <= HC_W'(OVS);
    else if (tick_i && hold_q != '0)    hold_q <= hold_q - HC_W'(1);
  end

  assign busy_o = (hold_q != '0);

  // ticks since the last detection while busy
  logic [BC_W-1:0] bc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      bc_q <= '0;
    else if (!busy_o || rise)         bc_q <= '0;
    else if (tick_i && bc_q != '1)    bc_q <= bc_q + BC_W'(1);
  end

  assert_busy_from_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(sync_q[SYNC-1] && !sync_q[SYNC] && en_i));

  assert_hold_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_q <= BC_W'(OVS));
endmodule

// File: rtl/irda_codec.sv
module irda_codec #(
  parameter int unsigned OVS       = irda_pkg::IRDA_OVS,
  parameter int unsigned PULSE     = irda_pkg::IRDA_PULSE,
  parameter int unsigned SYNC      = irda_pkg::IRDA_SYNC,
  parameter bit          RX_INVERT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ir_en_i,
  input  logic tx_nrz_i,
  input  logic ir_rx_i,
  output logic ir_tx_o,
  output logic rx_nrz_o
);
  logic pulse, busy, rx_pulse;

  // pick the pulse polarity of the receiver module
  generate
    if (RX_INVERT) begin : g_rx_inv
      assign rx_pulse = !ir_rx_i;
    end else begin : g_rx_dir
      assign rx_pulse = ir_rx_i;
    end
  endgenerate

  irda_tx_enc #(.OVS(OVS), .PULSE(PULSE)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .en_i    (ir_en_i),
    .tx_i    (tx_nrz_i),
    .pulse_o (pulse)
  );

  irda_rx_dec #(.OVS(OVS), .SYNC(SYNC)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .en_i   (ir_en_i),
    .rx_i   (rx_pulse),
    .busy_o (busy)
  );

  assign ir_tx_o  = ir_en_i ? pulse : tx_nrz_i;
  assign rx_nrz_o = ir_en_i ? !busy : ir_rx_i;
endmodule

// File: tb/irda_codec_tb.sv
module irda_codec_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic ir_en_i = 1'b1;
  logic tx_nrz_i = 1'b1;
  logic ir_rx_i = 1'b0;
  logic ir_tx_o, rx_nrz_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    bit    sel;   // 0: ir_tx_o, 1: rx_nrz_o
    bit    val;
    string req;
  } exp_t;
  exp_t exp_q[$];

  irda_codec u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .ir_en_i (ir_en_i),
    .tx_nrz_i(tx_nrz_i),
    .ir_rx_i (ir_rx_i),
    .ir_tx_o (ir_tx_o),
    .rx_nrz_o(rx_nrz_o)
  );

  always #5 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // tick on every posedge whose count is a multiple of 4
  initial forever begin
    @(negedge clk);
    tick_i = ((cyc + 1) % 4 == 0);
  end

  // monitor: compare the entries due in this cycle
  initial forever begin
    @(posedge clk);
    #2;
    for (int i = exp_q.size() - 1; i >= 0; i--) begin
      if (exp_q[i].at == cyc) begin
        bit act;
        act = exp_q[i].sel ? rx_nrz_o : ir_tx_o;
        checks++;
        if (act !== exp_q[i].val) begin
          errors++;
          $display("FAIL %s cyc=%0d %s actual=%0b expected=%0b", exp_q[i].req, cyc,
                   exp_q[i].sel ? "rx_nrz_o" : "ir_tx_o", act, exp_q[i].val);
        end
        exp_q.delete(i);
      end
    end
  end

  task automatic expect_at(int at, bit sel, bit val, string req);
    exp_t e;
    e.at = at; e.sel = sel; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic align;
    do @(negedge clk); while (cyc % 4 != 0);
  endtask

  // drive one bit right after a tick and hold it for one bit cell (16 ticks)
  task automatic send_bit(bit b, string req);
    int p;
    p = cyc;
    tx_nrz_i = b;
    if (!b) begin
      expect_at(p + 3,  1'b0, 1'b0, req);
      expect_at(p + 4,  1'b0, 1'b1, req);       // R3: rises at the sampling tick
      expect_at(p + 15, 1'b0, 1'b1, "R4");
      expect_at(p + 16, 1'b0, 1'b0, "R4");
    end else begin
      expect_at(p + 4,  1'b0, 1'b0, "R5");
      expect_at(p + 40, 1'b0, 1'b0, "R5");
    end
    wait_cyc(64);
  endtask

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    expect_at(cyc + 1, 1'b0, 1'b0, "R9");
    expect_at(cyc + 1, 1'b1, 1'b1, "R9");
    wait_cyc(8);

    // frame: start 0, data 1 0 0 1, stop 1
    align;
    send_bit(1'b0, "R3");
    send_bit(1'b1, "R5");
    send_bit(1'b0, "R3");
    send_bit(1'b0, "R6");   // second zero in a row: wrap-started cell
    send_bit(1'b1, "R5");
    send_bit(1'b1, "R5");   // idle stays low

    // single received pulse, 3 ticks long
    begin
      int q;
      align;
      q = cyc;
      ir_rx_i = 1'b1;
      expect_at(q + 2,  1'b1, 1'b1, "R7");
      expect_at(q + 3,  1'b1, 1'b0, "R7");
      expect_at(q + 63, 1'b1, 1'b0, "R8");
      expect_at(q + 64, 1'b1, 1'b1, "R8");
      wait_cyc(12);
      ir_rx_i = 1'b0;
      wait_cyc(60);
    end

    // retrigger: second pulse 8 ticks later restarts the window
    begin
      int q;
      align;
      q = cyc;
      ir_rx_i = 1'b1;
      expect_at(q + 3,  1'b1, 1'b0, "R7");
      expect_at(q + 64, 1'b1, 1'b0, "R8");
      expect_at(q + 95, 1'b1, 1'b0, "R8");
      expect_at(q + 96, 1'b1, 1'b1, "R8");
      wait_cyc(12);
      ir_rx_i = 1'b0;
      wait_cyc(20);
      ir_rx_i = 1'b1;
      wait_cyc(12);
      ir_rx_i = 1'b0;
      wait_cyc(70);
    end

    // passthrough with infrared mode off
    ir_en_i  = 1'b0;
    tx_nrz_i = 1'b0;
    ir_rx_i  = 1'b1;
    expect_at(cyc + 1, 1'b0, 1'b0, "R1");
    expect_at(cyc + 1, 1'b1, 1'b1, "R2");
    wait_cyc(2);
    tx_nrz_i = 1'b1;
    ir_rx_i  = 1'b0;
    expect_at(cyc + 1, 1'b0, 1'b1, "R1");
    expect_at(cyc + 1, 1'b1, 1'b0, "R2");
    wait_cyc(2);
    tx_nrz_i = 1'b0;
    expect_at(cyc + 1, 1'b0, 1'b0, "R1");
    expect_at(cyc + 20, 1'b0, 1'b0, "R1");    // no pulse shaping when off
    wait_cyc(24);
    tx_nrz_i = 1'b1;
    wait_cyc(4);

    foreach (exp_q[i]) begin
      errors++;
      $display("FAIL %s never checked at cyc=%0d actual=none expected=%0b",
               exp_q[i].req, exp_q[i].at, exp_q[i].val);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule